// File: doc/BRIEF.md
# Mesh Walk and Vector Store Sequencer

This block drives a small execution core across a two-dimensional grid of points. After a start pulse it visits every point in row-major order, the rows from 0 to the last row index and the columns from 0 to the last column index, with both limits inclusive. For each point it first writes the column and row numbers into two general-purpose registers of the core. It then pulses the core to run its microprogram from instruction zero, and it waits until the core reports an output vector. The two words of that vector are stored to memory through a valid/ready write port. When the last point has been handled, the block reports the number of points and raises a one-cycle interrupt.

The core signals every instruction it executes on `step_i`. If a point reaches the instruction limit without producing a vector, the sequencer abandons that point. It pulses `abort_o`, writes nothing for the point, and moves on to the next one. Each grid point owns an 8-byte slot in memory. The slots are placed with a fixed stride of 2^COL_W columns, so the slot of point (x, y) begins at base + 8*(2^COL_W*y + x).

The controller is a single enumerated state machine with eight states:
- `S_IDLE` waits for a start. A start moves it to `S_SETX`.
- `S_SETX` writes the column number. It always moves to `S_SETY`.
- `S_SETY` writes the row number. It moves to `S_LAUNCH`.
- `S_LAUNCH` issues the run pulse. It moves to `S_EXEC`.
- `S_EXEC` moves to `S_WRA` when a vector arrives, or to `S_ADV` when the instruction limit is hit.
- `S_WRA` stores word A. It moves to `S_WRB` once ready is accepted.
- `S_WRB` stores word B. It moves to `S_ADV` once ready is accepted.
- `S_ADV` returns to `S_SETX` when more points remain, or to `S_IDLE` after the last point, issuing the interrupt on that transition.

Top module: `mesh_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `irq_o`, `abort_o`, `run_o`, `gpr_we_o` and `mem_valid_o` are 0, and `lastdma_o` and `vertices_o` are 0.
- R2: A start pulse taken while idle makes `busy_o` read 1 from the next cycle. `busy_o` stays 1 until the mesh is finished.
- R3: Points are visited row-major: x runs 0..`hlast_i` inside y running 0..`vlast_i`.
- R4: For each point the block does three things in consecutive cycles. First it drives `gpr_we_o`=1 with `gpr_sel_o`=0 and `gpr_data_o`=x. Next it drives `gpr_we_o`=1 with `gpr_sel_o`=1 and `gpr_data_o`=y. Then it drives a one-cycle `run_o` pulse.
- R5: The vector of point (x, y) is written at address base + 8*(128*y + x), using the default 7-bit column field.
- R6: Word A is written first at that address, and word B second at address+4. Each word is byte-swapped, so input byte 0 (bits 7:0) lands in bits 31:24. Each write request holds its address and data stable until `mem_ready_i` is seen.
- R7: After word B is accepted, `lastdma_o` holds the address of word B.
- R8: A point ends when `vec_valid_i` is seen. A point that counts 2048 `step_i` pulses without a vector gets a one-cycle `abort_o`, makes no memory write, and the walk continues with the next point.
- R9: After the last point, `vertices_o` = (hlast+1)*(vlast+1), and `irq_o` is 1 for exactly one cycle. `busy_o` reads 0 in that same cycle.
- R10: A start pulse while `busy_o` is 1 has no effect on the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request pulse |
| hlast_i | input | COL_W | Last column index (inclusive) |
| vlast_i | input | ROW_W | Last row index (inclusive) |
| base_i | input | ADDR_W | Mesh base byte address |
| busy_o | output | 1 | Walk in progress |
| gpr_we_o | output | 1 | Register write strobe to the core |
| gpr_sel_o | output | 1 | 0 = column register, 1 = row register |
| gpr_data_o | output | 32 | Value for the selected register |
| run_o | output | 1 | Run-from-zero pulse to the core |
| step_i | input | 1 | One instruction executed by the core |
| vec_valid_i | input | 1 | Core produced its output vector |
| vec_a_i | input | 32 | First vector word |
| vec_b_i | input | 32 | Second vector word |
| mem_valid_o | output | 1 | Write request valid |
| mem_ready_i | input | 1 | Write request accepted |
| mem_addr_o | output | ADDR_W | Write byte address |
| mem_data_o | output | 32 | Write data, byte-swapped |
| lastdma_o | output | ADDR_W | Address of the latest word B write |
| vertices_o | output | COL_W+ROW_W+2 | Points in the finished mesh |
| abort_o | output | 1 | Point abandoned by instruction guard |
| irq_o | output | 1 | Mesh finished pulse |

## Verification
A wrong column or row counter shows up at the ports within three cycles of entering a point. It appears as a wrong value on `gpr_data_o` and, a few cycles later, as a wrong `mem_addr_o`. A state machine that takes a wrong branch shows up in the cycle after the branch. It either misses the `run_o` pulse, raises `mem_valid_o` for an aborted point, drops a held write before `mem_ready_i`, or fires `irq_o` while `busy_o` is still high. An instruction guard that is off by one shows up as an `abort_o` pulse when 2047 steps are followed by a vector, or as a missing pulse after 2048 steps.

// File: rtl/mesh_seq_pkg.sv
package mesh_seq_pkg;
    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETX,
        S_SETY,
        S_LAUNCH,
        S_EXEC,
        S_WRA,
        S_WRB,
        S_ADV
    } seq_state_t;

    // reverse byte order of a word for the memory side
    function automatic logic [DATA_W-1:0] swap_bytes(input logic [DATA_W-1:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction
endpackage

// File: rtl/mesh_seq_walk.sv
module mesh_seq_walk #(
    parameter int COL_W = 7,
    parameter int ROW_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             adv_i,
    input  logic [COL_W-1:0] hlast_i,
    input  logic [ROW_W-1:0] vlast_i,
    output logic [COL_W-1:0] x_o,
    output logic [ROW_W-1:0] y_o,
    output logic             last_o
);
    logic [COL_W-1:0] x_q;
    logic [ROW_W-1:0] y_q;
    logic             row_end;

    assign row_end = (x_q == hlast_i);
    assign last_o  = row_end && (y_q == vlast_i);

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            x_q <= '0;
            y_q <= '0;
        end else if (adv_i) begin
            if (row_end) begin
                x_q <= '0;
                y_q <= y_q + 1'b1;
            end else begin
                x_q <= x_q + 1'b1;
            end
        end
    end

    assign x_o = x_q;
    assign y_o = y_q;

    // R3: the walk never leaves the inclusive row range
    a_r3_row_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i && !last_o && row_end |=> (y_q != '0));
endmodule

// File: rtl/mesh_seq_guard.sv
module mesh_seq_guard #(
    parameter int STEP_LIMIT = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic step_i,
    output logic hit_o
);
    localparam int CNT_W = $clog2(STEP_LIMIT) + 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STEP_LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    assign hit_o = step_i && (cnt_q == LAST_CNT);

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (step_i && !hit_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mesh_seq_addr.sv
module mesh_seq_addr #(
    parameter int COL_W       = 7,
    parameter int ROW_W       = 7,
    parameter int ADDR_W      = 32,
    parameter int ENTRY_SHIFT = 3
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [COL_W-1:0]  x_i,
    input  logic [ROW_W-1:0]  y_i,
    input  logic              hi_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int OFF_W = ROW_W + COL_W + ENTRY_SHIFT;

    logic [OFF_W-1:0] slot_off;

    // fixed stride: the column field occupies exactly COL_W bits
    assign slot_off = {y_i, x_i, {ENTRY_SHIFT{1'b0}}};
    assign addr_o   = base_i + ADDR_W'(slot_off) + (hi_i ? ADDR_W'(4) : ADDR_W'(0));
endmodule

// File: rtl/mesh_seq.sv
module mesh_seq
    import mesh_seq_pkg::*;
#(
    parameter int COL_W      = 7,
    parameter int ROW_W      = 7,
    parameter int ADDR_W     = 32,
    parameter int STEP_LIMIT = 2048
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [COL_W-1:0]         hlast_i,
    input  logic [ROW_W-1:0]         vlast_i,
    input  logic [ADDR_W-1:0]        base_i,
    output logic                     busy_o,
    output logic                     gpr_we_o,
    output logic                     gpr_sel_o,
    output logic [31:0]              gpr_data_o,
    output logic                     run_o,
    input  logic                     step_i,
    input  logic                     vec_valid_i,
    input  logic [31:0]              vec_a_i,
    input  logic [31:0]              vec_b_i,
    output logic                     mem_valid_o,
    input  logic                     mem_ready_i,
    output logic [ADDR_W-1:0]        mem_addr_o,
    output logic [31:0]              mem_data_o,
    output logic [ADDR_W-1:0]        lastdma_o,
    output logic [COL_W+ROW_W+1:0]   vertices_o,
    output logic                     abort_o,
    output logic                     irq_o
);
    localparam int VCNT_W = COL_W + ROW_W + 2;

    seq_state_t        state_q, state_d;
    logic [COL_W-1:0]  x_cur;
    logic [ROW_W-1:0]  y_cur;
    logic              mesh_last;
    logic              guard_hit;
    logic              walk_clr, walk_adv;
    logic [DATA_W-1:0] va_q, vb_q;
    logic [ADDR_W-1:0] cur_addr;
    logic              irq_q, abort_q;
    logic [ADDR_W-1:0] lastdma_q;
    logic [VCNT_W-1:0] vcnt_q;
    logic [VCNT_W-1:0] cols, rows;

    assign walk_clr = (state_q == S_IDLE) && start_i;
    assign walk_adv = (state_q == S_ADV) && !mesh_last;

    mesh_seq_walk #(.COL_W(COL_W), .ROW_W(ROW_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .clr_i(walk_clr), .adv_i(walk_adv),
        .hlast_i(hlast_i), .vlast_i(vlast_i),
        .x_o(x_cur), .y_o(y_cur), .last_o(mesh_last)
    );

    mesh_seq_guard #(.STEP_LIMIT(STEP_LIMIT)) u_guard (
        .clk(clk), .rst_n(rst_n),
        .clr_i(state_q == S_LAUNCH),
        .step_i((state_q == S_EXEC) && step_i && !vec_valid_i),
        .hit_o(guard_hit)
    );

    mesh_seq_addr #(.COL_W(COL_W), .ROW_W(ROW_W), .ADDR_W(ADDR_W), .ENTRY_SHIFT(3)) u_addr (
        .base_i(base_i), .x_i(x_cur), .y_i(y_cur),
        .hi_i(state_q == S_WRB), .addr_o(cur_addr)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start_i) state_d = S_SETX;
            S_SETX:   state_d = S_SETY;
            S_SETY:   state_d = S_LAUNCH;
            S_LAUNCH: state_d = S_EXEC;
            S_EXEC: begin
                if (vec_valid_i)    state_d = S_WRA;
                else if (guard_hit) state_d = S_ADV;
            end
            S_WRA:    if (mem_ready_i) state_d = S_WRB;
            S_WRB:    if (mem_ready_i) state_d = S_ADV;
            S_ADV:    state_d = mesh_last ? S_IDLE : S_SETX;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        busy_o      = (state_q != S_IDLE);
        gpr_we_o    = (state_q == S_SETX) || (state_q == S_SETY);
        gpr_sel_o   = (state_q == S_SETY);
        gpr_data_o  = (state_q == S_SETY) ? DATA_W'(y_cur) : DATA_W'(x_cur);
        run_o       = (state_q == S_LAUNCH);
        mem_valid_o = (state_q == S_WRA) || (state_q == S_WRB);
        mem_addr_o  = cur_addr;
        mem_data_o  = swap_bytes((state_q == S_WRB) ? vb_q : va_q);
    end

    assign cols = VCNT_W'(hlast_i) + 1'b1;
    assign rows = VCNT_W'(vlast_i) + 1'b1;

    // captured data and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q      <= '0;
            vb_q      <= '0;
            lastdma_q <= '0;
            vcnt_q    <= '0;
            irq_q     <= 1'b0;
            abort_q   <= 1'b0;
        end else begin
            irq_q   <= (state_q == S_ADV) && mesh_last;
            abort_q <= (state_q == S_EXEC) && !vec_valid_i && guard_hit;
            if ((state_q == S_EXEC) && vec_valid_i) begin
                va_q <= vec_a_i;
                vb_q <= vec_b_i;
            end
            if ((state_q == S_WRB) && mem_ready_i) lastdma_q <= cur_addr;
            if ((state_q == S_ADV) && mesh_last)   vcnt_q    <= cols * rows;
        end
    end

    assign lastdma_o  = lastdma_q;
    assign vertices_o = vcnt_q;
    assign irq_o      = irq_q;
    assign abort_o    = abort_q;

    // R6: a pending write holds address and data
    a_r6_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o));
    // R9: interrupt is a single cycle and coincides with idle
    a_r9_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    a_r9_irq_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !busy_o);
    // R4: run request is a single cycle
    a_r4_run_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |=> !run_o);
    // R8: an abandoned point makes no write
    a_r8_abort_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> !mem_valid_o);
endmodule

// File: tb/mesh_seq_tb.sv
module mesh_seq_tb;
    localparam int LIMIT = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [6:0]  hlast_i = '0;
    logic [6:0]  vlast_i = '0;
    logic [31:0] base_i = '0;
    logic        busy_o, gpr_we_o, gpr_sel_o, run_o;
    logic [31:0] gpr_data_o;
    logic        step_i = 1'b0;
    logic        vec_valid_i = 1'b0;
    logic [31:0] vec_a_i = '0;
    logic [31:0] vec_b_i = '0;
    logic        mem_valid_o;
    logic        mem_ready_i = 1'b0;
    logic [31:0] mem_addr_o, mem_data_o, lastdma_o;
    logic [15:0] vertices_o;
    logic        abort_o, irq_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    mesh_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .hlast_i(hlast_i), .vlast_i(vlast_i), .base_i(base_i),
        .busy_o(busy_o), .gpr_we_o(gpr_we_o), .gpr_sel_o(gpr_sel_o),
        .gpr_data_o(gpr_data_o), .run_o(run_o), .step_i(step_i),
        .vec_valid_i(vec_valid_i), .vec_a_i(vec_a_i), .vec_b_i(vec_b_i),
        .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i),
        .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
        .lastdma_o(lastdma_o), .vertices_o(vertices_o),
        .abort_o(abort_o), .irq_o(irq_o)
    );

    // mesh table: last column, last row, base, steps per point, ready delay, start poke
    localparam int          T_N = 4;
    localparam int          T_H    [T_N] = '{0, 2, 1, 3};
    localparam int          T_V    [T_N] = '{0, 1, 2, 0};
    localparam logic [31:0] T_BASE [T_N] = '{32'h0000_1000, 32'h8000_0000, 32'h0000_0040, 32'h0000_2000};
    localparam int          T_STEP [T_N] = '{0, 3, 1, 5};
    localparam int          T_RDLY [T_N] = '{0, 2, 1, 0};
    localparam int          T_POKE [T_N] = '{0, 1, 0, 0};

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] swp(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [31:0] slot(input logic [31:0] b, input int x, input int y);
        return b + 32'(8 * (128 * y + x));
    endfunction

    // entered at the negedge where the column write is expected; leaves at the advance cycle
    task automatic do_point(input int x, input int y, input logic [31:0] b,
                            input int steps, input int rdly, input bit poke, input bit expect_abort);
        logic [31:0] a_w, b_w, adr;
        a_w = 32'h1234_0000 ^ 32'((y << 8) | x);
        b_w = 32'hCAFE_0000 + 32'((x << 8) | y);
        adr = slot(b, x, y);
        chk(gpr_we_o && !gpr_sel_o && gpr_data_o == 32'(x), "R3/R4 column write", gpr_data_o, 32'(x));
        @(negedge clk);
        chk(gpr_we_o && gpr_sel_o && gpr_data_o == 32'(y), "R3/R4 row write", gpr_data_o, 32'(y));
        @(negedge clk);
        chk(run_o && !gpr_we_o, "R4 run pulse", {31'd0, run_o}, 32'd1);
        @(negedge clk);
        if (poke) begin
            start_i = 1'b1;          // R10: start while busy
            @(negedge clk);
            start_i = 1'b0;
            chk(busy_o, "R10 busy after ignored start", {31'd0, busy_o}, 32'd1);
        end
        for (int i = 0; i < steps; i++) begin
            step_i = 1'b1;
            @(negedge clk);
        end
        step_i = 1'b0;
        if (expect_abort) begin
            chk(abort_o && !mem_valid_o, "R8 abort without write", {30'd0, abort_o, mem_valid_o}, 32'd2);
            return;
        end
        chk(!abort_o, "R8 no abort before limit", {31'd0, abort_o}, 32'd0);
        vec_valid_i = 1'b1; vec_a_i = a_w; vec_b_i = b_w;
        @(negedge clk);
        vec_valid_i = 1'b0;
        chk(mem_valid_o && mem_addr_o == adr, "R5 word A address", mem_addr_o, adr);
        chk(mem_data_o == swp(a_w), "R6 word A data", mem_data_o, swp(a_w));
        for (int d = 0; d < rdly; d++) begin
            @(negedge clk);
            chk(mem_valid_o && mem_addr_o == adr && mem_data_o == swp(a_w), "R6 hold word A", mem_addr_o, adr);
        end
        mem_ready_i = 1'b1;
        @(negedge clk);
        mem_ready_i = 1'b0;
        chk(mem_valid_o && mem_addr_o == adr + 32'd4, "R6 word B address", mem_addr_o, adr + 32'd4);
        chk(mem_data_o == swp(b_w), "R6 word B data", mem_data_o, swp(b_w));
        for (int d = 0; d < rdly; d++) begin
            @(negedge clk);
            chk(mem_valid_o && mem_data_o == swp(b_w), "R6 hold word B", mem_data_o, swp(b_w));
        end
        mem_ready_i = 1'b1;
        @(negedge clk);
        mem_ready_i = 1'b0;
        chk(!mem_valid_o && lastdma_o == adr + 32'd4, "R7 last write address", lastdma_o, adr + 32'd4);
    endtask

    task automatic run_mesh(input int h, input int v, input logic [31:0] b, input int steps,
                            input int rdly, input bit poke, input int abort_idx);
        hlast_i = 7'(h); vlast_i = 7'(v); base_i = b;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o, "R2 busy after start", {31'd0, busy_o}, 32'd1);
        for (int y = 0; y <= v; y++) begin
            for (int x = 0; x <= h; x++) begin
                int idx;
                idx = y * (h + 1) + x;
                if (idx == abort_idx)
                    do_point(x, y, b, LIMIT, rdly, 1'b0, 1'b1);
                else
                    do_point(x, y, b, steps, rdly, poke && idx == 0, 1'b0);
                @(negedge clk);
                if (!(x == h && y == v))
                    chk(busy_o && !irq_o, "R2 busy between points", {30'd0, busy_o, irq_o}, 32'd2);
            end
        end
        chk(irq_o && !busy_o, "R9 irq with busy low", {30'd0, irq_o, busy_o}, 32'd2);
        chk(vertices_o == 16'((h + 1) * (v + 1)), "R9 vertex count", 32'(vertices_o), 32'((h + 1) * (v + 1)));
        chk(lastdma_o == slot(b, h, v) + 32'd4, "R7 final last write", lastdma_o, slot(b, h, v) + 32'd4);
        @(negedge clk);
        chk(!irq_o && !busy_o, "R9 irq one cycle", {31'd0, irq_o}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy_o && !irq_o && !abort_o && !run_o && !gpr_we_o && !mem_valid_o, "R1 idle outputs",
            {26'd0, busy_o, irq_o, abort_o, run_o, gpr_we_o, mem_valid_o}, 32'd0);
        chk(lastdma_o == 32'd0 && vertices_o == 16'd0, "R1 cleared results", lastdma_o, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o, "R1 stays idle without start", {31'd0, busy_o}, 32'd0);

        for (int t = 0; t < T_N; t++)
            run_mesh(T_H[t], T_V[t], T_BASE[t], T_STEP[t], T_RDLY[t], T_POKE[t] != 0, -1);

        // R8: first point runs away, second completes; then one point at exactly limit-1 steps
        run_mesh(1, 0, 32'h0000_3000, 2, 1, 1'b0, 0);
        run_mesh(0, 0, 32'h0000_5000, LIMIT - 1, 0, 1'b0, -1);
        // R8: abort in a middle point of a larger mesh
        run_mesh(2, 1, 32'h0001_0000, 1, 0, 1'b0, 2);

        repeat (2) @(negedge clk);
        chk(!busy_o && !irq_o, "R1 idle after runs", {30'd0, busy_o, irq_o}, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule